// File: doc/BRIEF.md
# Clamped-Duty PWM Generator

This block drives one pulse-width-modulated output. A 7-bit code sets the duty cycle, and a 5-bit selector sets the period. The selector looks up a repetition length in an irregular period table. Every period is split into 128 equal slots, and the output is high for `code` slots, counted from the start of the period. Code 0 keeps the output low for the whole period. Code 127 keeps it high for the whole period, so the 127/128 step never appears.

At the short periods the linear high or low time can be shorter than a fixed minimum pulse. In that case the minimum replaces it, so the output always gives a readable edge. New code and selector values are taken only at a period boundary, so a period is never cut short or stretched. A selector value of 0 is an invalid setting. It stops all activity and raises a flag. The slot length is `BASE_SLOT` clocks per table unit, and the minimum pulse is `MIN_PULSE` clocks. Both are parameters (defaults 8 and 50, which give 160 ns and 1 us at 50 MHz).

Top module: `clamp_pwm`

## Requirements
- R1: While `rstN` is low, and after it is released with `en` low, `pwmOut` is 0.
- R2: A period latched with code 0 keeps `pwmOut` low for all of its cycles.
- R3: A period latched with code 127 keeps `pwmOut` high for all of its cycles.
- R4: For codes 1 to 126, `pwmOut` is high for the first H cycles of the period and low for the rest. H is code × P / 128, where P is the period in clocks, unless R5 or R6 changes it.
- R5: For codes 1 to 126, H is never below `MIN_PULSE` clocks.
- R6: For codes 1 to 126, the low time P − H is never below `MIN_PULSE` clocks. Where this and R5 both apply, this one is applied last.
- R7: The period is P = 128 × `BASE_SLOT` × U clocks, where U is the table entry for the selector s. U = s for s = 1 to 4. U = 6 for s = 5. U = 8 for s = 6. U = 8 × (s − 5) for s = 7 to 30. U = 224 for s = 31.
- R8: Selector 0 is never latched. If it is present when a period would start, or at the end of a period, `pwmOut` stays low and no period runs.
- R9: When `en` is low at a clock edge, `pwmOut` is low after that edge.
- R10: Changes to code or selector during a running period have no effect until its last cycle has passed. The next period starts immediately after it with the new values.
- R11: `invalidCfg` is high exactly while `freqSel` is 0, whatever the state of `en`.
- R12: From idle, the first period starts at the first edge with `en` high and `freqSel` non-zero. Its counter starts at 0, so the output is high from that edge for any code other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| dutyCode | input | 7 | Duty code 0..127 |
| freqSel | input | 5 | Period table index, 0 invalid |
| pwmOut | output | 1 | PWM output |
| invalidCfg | output | 1 | High while the selector is 0 |

## Verification
A corrupted period counter or table entry shows at the ports as a rising or falling edge in the wrong cycle. This appears within the first period after the fault, since every clock is compared with a behavioural reference. A code or selector latched at the wrong time shows as a high time that differs from the formula for the period that is running, and the per-period high count exposes this when that period ends. A wrong clamp shows only at the short-period selectors, or at the extreme codes, so those combinations are driven on purpose.

// File: rtl/clamp_pwm_pkg.sv
package clamp_pwm_pkg;

  typedef struct packed {
    logic load;  // take new code and selector, restart the period count
    logic run;   // a period is in progress
  } pwmStrobe_t;

  // repetition length in table units for a selector value
  function automatic logic [7:0] periodUnits(input logic [4:0] sel);
    logic [7:0] u;
    if (sel == 5'd0)       u = 8'd0;
    else if (sel <= 5'd4)  u = {3'b000, sel};
    else if (sel == 5'd5)  u = 8'd6;
    else if (sel == 5'd6)  u = 8'd8;
    else if (sel == 5'd31) u = 8'd224;
    else                   u = ({3'b000, sel} - 8'd5) << 3;
    return u;
  endfunction

endpackage

// File: rtl/clamp_pwm_ctrl.sv
module clamp_pwm_ctrl
  import clamp_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic [4:0] freqSel,
  input  logic       periodEnd,
  output pwmStrobe_t strobe
);
  logic active;
  logic selOk;
  logic load;
  logic stop;

  assign selOk = (freqSel != 5'd0);
  assign load  = en && selOk && (!active || periodEnd);
  assign stop  = active && !load && (!en || periodEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     active <= 1'b0;
    else if (load) active <= 1'b1;
    else if (stop) active <= 1'b0;
  end

  assign strobe.load = load;
  assign strobe.run  = active;
endmodule

// File: rtl/clamp_pwm_dp.sv
module clamp_pwm_dp
  import clamp_pwm_pkg::*;
#(
  parameter int BASE_SLOT = 8,
  parameter int MIN_PULSE = 50,
  parameter int CNT_W     = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] dutyCode,
  input  logic [4:0] freqSel,
  input  pwmStrobe_t strobe,
  output logic       periodEnd,
  output logic       cntZero,
  output logic [6:0] curCode,
  output logic       pwmOut
);
  localparam logic [CNT_W-1:0] MinCyc  = CNT_W'(MIN_PULSE);
  localparam logic [CNT_W-1:0] BaseCyc = CNT_W'(BASE_SLOT);

  logic [CNT_W-1:0] cnt;
  logic [4:0]       curSel;
  logic [CNT_W-1:0] slotCyc;
  logic [CNT_W-1:0] periodCyc;
  logic [CNT_W-1:0] linCyc;
  logic [CNT_W-1:0] highCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      curCode <= '0;
      curSel  <= '0;
    end else if (strobe.load) begin
      cnt     <= '0;
      curCode <= dutyCode;
      curSel  <= freqSel;
    end else if (strobe.run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign slotCyc   = CNT_W'(periodUnits(curSel)) * BaseCyc;
  assign periodCyc = slotCyc << 7;
  assign linCyc    = CNT_W'(curCode) * slotCyc;

  always_comb begin
    if (curCode == 7'd0) begin
      highCyc = '0;
    end else if (curCode == 7'd127) begin
      highCyc = periodCyc;
    end else begin
      highCyc = (linCyc < MinCyc) ? MinCyc : linCyc;
      if (highCyc > periodCyc - MinCyc) highCyc = periodCyc - MinCyc;
    end
  end

  assign periodEnd = strobe.run && (cnt == periodCyc - 1'b1);
  assign cntZero   = (cnt == '0);
  assign pwmOut    = strobe.run && (cnt < highCyc);
endmodule

// File: rtl/clamp_pwm.sv
module clamp_pwm
  import clamp_pwm_pkg::*;
#(
  parameter int BASE_SLOT = 8,
  parameter int MIN_PULSE = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic [6:0] dutyCode,
  input  logic [4:0] freqSel,
  output logic       pwmOut,
  output logic       invalidCfg
);
  localparam int CNT_W = $clog2(224 * 128 * BASE_SLOT + 1);

  pwmStrobe_t strobe;
  logic       periodEnd;
  logic       cntZero;
  logic [6:0] curCode;
  logic       active;

  clamp_pwm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .en        (en),
    .freqSel   (freqSel),
    .periodEnd (periodEnd),
    .strobe    (strobe)
  );

  clamp_pwm_dp #(
    .BASE_SLOT (BASE_SLOT),
    .MIN_PULSE (MIN_PULSE),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dutyCode  (dutyCode),
    .freqSel   (freqSel),
    .strobe    (strobe),
    .periodEnd (periodEnd),
    .cntZero   (cntZero),
    .curCode   (curCode),
    .pwmOut    (pwmOut)
  );

  assign active     = strobe.run;
  assign invalidCfg = (freqSel == 5'd0);
endmodule

// File: rtl/clamp_pwm_chk.sv
module clamp_pwm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       en,
  input logic [4:0] freqSel,
  input logic       pwmOut,
  input logic       active,
  input logic       periodEnd,
  input logic       cntZero,
  input logic [6:0] curCode
);
  a_r9_disable_low: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !pwmOut);

  a_r8_zero_sel_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!active && freqSel == 5'd0) |=> !pwmOut);

  a_r2_code_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (active && curCode == 7'd0) |-> !pwmOut);

  a_r3_code_full_high: assert property (@(posedge clk) disable iff (!rstN)
    (active && curCode == 7'd127) |-> pwmOut);

  a_r5_starts_high: assert property (@(posedge clk) disable iff (!rstN)
    (active && cntZero && curCode != 7'd0) |-> pwmOut);

  a_r6_ends_low: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && curCode != 7'd127) |-> !pwmOut);

  a_r10_code_held: assert property (@(posedge clk) disable iff (!rstN)
    (active && !periodEnd) |=> $stable(curCode));
endmodule

bind clamp_pwm clamp_pwm_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .en        (en),
  .freqSel   (freqSel),
  .pwmOut    (pwmOut),
  .active    (active),
  .periodEnd (periodEnd),
  .cntZero   (cntZero),
  .curCode   (curCode)
);

// File: tb/sim_clamp_pwm.sv
`timescale 1ns/1ps
module sim_clamp_pwm;
  localparam int BASE = 1;
  localparam int MINP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [6:0] dutyCode = '0;
  logic [4:0] freqSel = '0;
  logic       pwmOut;
  logic       invalidCfg;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  bit mAct = 1'b0;
  int mCnt = 0;
  int mCode = 0;
  int mSel = 0;
  int highSeen = 0;

  always #10 clk = ~clk;

  clamp_pwm #(.BASE_SLOT(BASE), .MIN_PULSE(MINP)) u0 (
    .clk(clk), .rstN(rstN), .en(en), .dutyCode(dutyCode),
    .freqSel(freqSel), .pwmOut(pwmOut), .invalidCfg(invalidCfg)
  );

  // R7: table of lengths in units
  function automatic int units(int s);
    case (s)
      0: return 0;
      1, 2, 3, 4: return s;
      5: return 6;
      6: return 8;
      31: return 224;
      default: return 8 * (s - 5);
    endcase
  endfunction

  function automatic int periodOf(int s);
    return 128 * BASE * units(s);
  endfunction

  // R2..R6 expected high cycles
  function automatic int highOf(int c, int s);
    int p, h;
    p = periodOf(s);
    if (c == 0) return 0;
    if (c == 127) return p;
    h = (c * p) / 128;
    if (h < MINP) h = MINP;
    if (p - h < MINP) h = p - MINP;
    return h;
  endfunction

  function automatic string tagOf(int c, int s);
    int p, lin;
    p = periodOf(s);
    lin = (c * p) / 128;
    if (c == 0) return "R2";
    if (c == 127) return "R3";
    if (p - lin < MINP) return "R6";
    if (lin < MINP) return "R5";
    return "R4";
  endfunction

  // reference update, inputs are stable at the edge
  always @(posedge clk) begin
    bit pEnd, load;
    if (!rstN) begin
      mAct = 1'b0; mCnt = 0; mCode = 0; mSel = 0; highSeen = 0;
    end else begin
      pEnd = mAct && (mCnt == periodOf(mSel) - 1);
      if (pEnd) begin
        vectors++;
        if (highSeen != highOf(mCode, mSel)) begin
          miscompares++;
          $display("FAIL %s R7 high count per period: actual %0d expected %0d (code %0d sel %0d)",
                   tagOf(mCode, mSel), highSeen, highOf(mCode, mSel), mCode, mSel);
        end
      end
      load = en && (freqSel != 0) && (!mAct || pEnd);
      if (load) begin
        mAct = 1'b1; mCnt = 0; mCode = dutyCode; mSel = freqSel;
        highSeen = 0;
      end else if (mAct && (!en || pEnd)) begin
        mAct = 1'b0; highSeen = 0;
      end else if (mAct) begin
        mCnt++;
      end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    bit expOut;
    string tag;
    if (!done) begin
      expOut = mAct && (mCnt < highOf(mCode, mSel));
      if (!rstN) tag = "R1";
      else if (!en) tag = "R9";
      else if (!mAct) tag = (freqSel == 0) ? "R8" : "R12";
      else tag = tagOf(mCode, mSel);
      vectors++;
      if (pwmOut !== expOut) begin
        miscompares++;
        $display("FAIL %s pwmOut at cnt %0d: actual %b expected %b", tag, mCnt, pwmOut, expOut);
      end
      vectors++;
      if (invalidCfg !== (freqSel == 5'd0)) begin
        miscompares++;
        $display("FAIL R11 invalidCfg: actual %b expected %b", invalidCfg, (freqSel == 5'd0));
      end
      if (mAct && pwmOut === 1'b1) highSeen++;
    end
  end

  task automatic setIn(bit e, int c, int s);
    @(negedge clk); #1;
    en = e; dutyCode = 7'(c); freqSel = 5'(s);
  endtask

  task automatic runPeriods(int s, int n);
    repeat (n * periodOf(s)) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);                 // R1 during reset
    setIn(1'b0, 64, 1);
    rstN = 1'b1;
    repeat (5) @(posedge clk);                 // R1 idle with en low
    setIn(1'b1, 64, 1);                        // R12, R4 mid code
    runPeriods(1, 2);
    repeat (20) @(posedge clk);
    setIn(1'b1, 1, 1);                         // R10 change mid period; R5 clamp
    runPeriods(1, 3);
    setIn(1'b1, 126, 1);                       // R6 clamp
    runPeriods(1, 2);
    setIn(1'b1, 0, 1);                         // R2
    runPeriods(1, 2);
    setIn(1'b1, 127, 2);                       // R3, R7
    runPeriods(2, 2);
    setIn(1'b1, 1, 2);                         // R5 at selector 2
    runPeriods(2, 2);
    setIn(1'b1, 126, 4);
    runPeriods(4, 2);
    setIn(1'b1, 37, 5);
    runPeriods(5, 2);
    setIn(1'b1, 37, 7);                        // R7 longer table entry
    runPeriods(7, 2);
    setIn(1'b1, 90, 0);                        // R8 at boundary, R11
    runPeriods(7, 2);
    setIn(1'b0, 90, 0);                        // R11 with en low
    repeat (10) @(posedge clk);
    setIn(1'b1, 100, 3);
    repeat (200) @(posedge clk);
    setIn(1'b0, 100, 3);                       // R9 disable mid period
    repeat (30) @(posedge clk);
    setIn(1'b1, 100, 31);                      // R7 slowest
    runPeriods(31, 1);
    setIn(1'b1, 3, 30);
    runPeriods(30, 1);
    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule